// File: doc/BRIEF.md
# Queue-based storage controller register file

This block is the memory-mapped register front end of a host-attached storage controller that works through submission and completion queues. It takes single 32-bit reads and writes on a plain register bus (write strobe, read strobe, byte offset, byte enables, write data). It returns read data and an error pulse one cycle later. It holds the capability and version words, the interrupt mask, the controller configuration and status words, the admin queue sizes and the two admin queue base addresses. It hands the base addresses, the sizes, the mask and a ready flag to the command engine that sits behind it.

A write to the configuration word runs the enable and shutdown handshakes, and the status word shows the result on the next cycle. Offsets from 0x1000 upward form a doorbell window of 8-byte slots, one slot per queue. A legal doorbell write becomes a one-cycle event that carries the queue number, a submission-or-completion flag and the 16-bit pointer value. Fetching and executing commands, memory traffic, interrupt vector tables and I/O queue setup are done by other blocks.

Top module: `sqc_regblk`

## Requirements
- R1: After synchronous reset, `ctrl_ready` is 0, `int_mask` is 0, both queue bases and both queue sizes are 0, `db_valid` and `bus_err` are 0, and the status word (offset 0x1C) reads 0.
- R2: Offset 0x00 reads 0x0A010010: timeout 10 in bits 31:24, contiguous-queues flag in bit 16, and maximum queue entries 0x10 in bits 15:0. Offset 0x04 reads 0 (doorbell stride 0 and page size codes 0), and offset 0x08 reads 0x00010000. Writes to these offsets and to the status word are ignored and raise no error.
- R3: A write to the configuration word (0x14) that sets bit 0 while the stored bit 0 is 0 clears the interrupt mask and the shutdown state, and sets ready. Ready is bit 0 of the status word and drives `ctrl_ready` from the next cycle. The admin queue sizes and bases keep their values.
- R4: A write to 0x14 that clears bit 0 while the stored bit 0 is 1 clears ready and leaves the shutdown state unchanged.
- R5: The shutdown request is bits 15:14 of the configuration word. The code 1 (normal) or 2 (abrupt) sets the shutdown state, bits 3:2 of the status word, to 2'b10 (complete). The codes 0 and 3 leave it as it is. When a single write raises bit 0 and carries code 1 or 2, the status word ends at 0x9. The configuration word reads back the written value ANDed with 0x00FFFFF1.
- R6: A write to 0x28 or 0x30 stores bits 31:12 of the low half of the submission or completion queue base, and bits 11:0 always read as 0. A write to 0x2C or 0x34 fills bits 63:32 of that base. The bases appear on `asq_base` and `acq_base`.
- R7: The admin queue attribute word (0x24) holds the submission size in bits 11:0 and the completion size in bits 27:16. It reads back ANDed with 0x0FFF0FFF and drives `asq_entries` and `acq_entries`.
- R8: A write to 0x0C ORs the data into the interrupt mask, and a write to 0x10 clears the bits that are set in the data. Both offsets read the mask.
- R9: A write at offset 0x1000 + 8·q (q ≤ MAX_QID, default 1) produces `db_valid` for exactly one cycle, starting the cycle after the write. The event has `db_qid` = q, `db_is_cq` = 0 and `db_value` = data bits 15:0. At offset 0x1004 + 8·q the event is the same except that `db_is_cq` = 1.
- R10: A doorbell write whose queue number is above MAX_QID produces no event and raises `bus_err` for one cycle.
- R11: An access with byte enables other than 4'hF, or with an unmapped or unaligned offset, raises `bus_err` for one cycle after the access. Such a read returns 0, and such a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 13 | Byte offset |
| bus_be | input | 4 | Byte enables, 4'hF required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| bus_err | output | 1 | One-cycle access error pulse |
| ctrl_ready | output | 1 | Controller ready |
| int_mask | output | 32 | Interrupt mask |
| asq_base | output | 64 | Admin submission queue base |
| acq_base | output | 64 | Admin completion queue base |
| asq_entries | output | 12 | Admin submission queue size field |
| acq_entries | output | 12 | Admin completion queue size field |
| db_valid | output | 1 | Doorbell event strobe |
| db_qid | output | QID_W | Doorbell queue number |
| db_is_cq | output | 1 | 1 = completion head, 0 = submission tail |
| db_value | output | 16 | Doorbell pointer value |

## Verification
The enable reset and the shutdown report both act on the status word, and a single configuration write can trigger both of them. The bench first leaves the shutdown state at complete. It then clears enable and writes a word that raises enable with shutdown code 2. The status word must read 0x9, which shows that the reset clear came first and the shutdown update took precedence. An earlier write that raises enable with code 0 must read 0x1, which shows that the clear alone takes effect. For doorbells, the bench checks that an in-range write produces an event with no error and that an out-of-range write produces an error with no event.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    localparam int OFF_W  = 13;
    localparam int DATA_W = 32;
    localparam int PTR_W  = 16;
    localparam int QSZ_W  = 12;

    localparam logic [DATA_W-1:0] VER_WORD  = 32'h0001_0000;
    localparam logic [DATA_W-1:0] CFG_KEEP  = 32'h00FF_FFF1;
    localparam logic [DATA_W-1:0] AQA_KEEP  = 32'h0FFF_0FFF;

    typedef enum logic [3:0] {
        RS_CAP_LO, RS_CAP_HI, RS_VER, RS_MSET, RS_MCLR, RS_CFG, RS_STAT,
        RS_AQA, RS_ASQ_LO, RS_ASQ_HI, RS_ACQ_LO, RS_ACQ_HI, RS_DBELL, RS_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        SH_IDLE = 2'b00,
        SH_BUSY = 2'b01,
        SH_DONE = 2'b10
    } shdn_e;

    function automatic logic [DATA_W-1:0] cap_low(input int mqes, input int tmo);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[15:0]  = mqes[15:0];
        w[16]    = 1'b1;
        w[31:24] = tmo[7:0];
        return w;
    endfunction

    function automatic reg_sel_e decode_offset(input logic [OFF_W-1:0] off);
        reg_sel_e s;
        if (off[1:0] != 2'b00)  s = RS_NONE;
        else if (off[OFF_W-1])  s = RS_DBELL;
        else begin
            case (off[OFF_W-2:0])
                12'h000: s = RS_CAP_LO;
                12'h004: s = RS_CAP_HI;
                12'h008: s = RS_VER;
                12'h00C: s = RS_MSET;
                12'h010: s = RS_MCLR;
                12'h014: s = RS_CFG;
                12'h01C: s = RS_STAT;
                12'h024: s = RS_AQA;
                12'h028: s = RS_ASQ_LO;
                12'h02C: s = RS_ASQ_HI;
                12'h030: s = RS_ACQ_LO;
                12'h034: s = RS_ACQ_HI;
                default: s = RS_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/sqc_cfg_regs.sv
module sqc_cfg_regs
    import sqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_word,
    output logic [DATA_W-1:0] stat_word,
    output logic [DATA_W-1:0] aqa_word,
    output logic [DATA_W-1:0] mask,
    output logic [63:0]       asq,
    output logic [63:0]       acq,
    output logic              rdy
);

    shdn_e shst;
    logic  en_rise, en_fall, shdn_req;

    assign en_rise  = !cfg_word[0] && wdata[0];
    assign en_fall  = cfg_word[0] && !wdata[0];
    assign shdn_req = (wdata[15:14] == 2'd1) || (wdata[15:14] == 2'd2);

    assign stat_word = {{(DATA_W-4){1'b0}}, shst, 1'b0, rdy};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_word <= '0;
            aqa_word <= '0;
            mask     <= '0;
            asq      <= '0;
            acq      <= '0;
            rdy      <= 1'b0;
            shst     <= SH_IDLE;
        end else if (wr_en) begin
            case (sel)
                RS_MSET:   mask <= mask | wdata;
                RS_MCLR:   mask <= mask & ~wdata;
                RS_AQA:    aqa_word <= wdata & AQA_KEEP;
                RS_ASQ_LO: asq[31:0]  <= {wdata[31:12], 12'h000};
                RS_ASQ_HI: asq[63:32] <= wdata;
                RS_ACQ_LO: acq[31:0]  <= {wdata[31:12], 12'h000};
                RS_ACQ_HI: acq[63:32] <= wdata;
                RS_CFG: begin
                    cfg_word <= wdata & CFG_KEEP;
                    if (en_rise) begin
                        mask <= '0;
                        rdy  <= 1'b1;
                        shst <= SH_IDLE;
                    end else if (en_fall) begin
                        rdy  <= 1'b0;
                    end
                    if (shdn_req) shst <= SH_DONE;
                end
                default: ;
            endcase
        end
    end

    assert_ready_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> $past(wr_en && sel == RS_CFG && wdata[0]));

    assert_ready_drop_R4: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && sel == RS_CFG && !wdata[0]) |-> !rdy);

    assert_asq_low_R6: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && sel == RS_ASQ_LO) |-> asq[31:0] == {$past(wdata[31:12]), 12'h000});

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && sel == RS_MSET) |-> (mask & $past(wdata)) == $past(wdata));

endmodule

// File: rtl/sqc_doorbell.sv
module sqc_doorbell
    import sqc_pkg::*;
#(
    parameter int MAX_QID = 1,
    parameter int QID_W   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [9:0]       dw_idx,
    input  logic [PTR_W-1:0] wptr,
    output logic             drop,
    output logic             db_valid,
    output logic [QID_W-1:0] db_qid,
    output logic             db_is_cq,
    output logic [PTR_W-1:0] db_value
);

    logic [8:0] slot;

    assign slot = dw_idx[9:1];
    assign drop = int'(slot) > MAX_QID;

    always_ff @(posedge clk) begin
        if (rst) begin
            db_valid <= 1'b0;
            db_qid   <= '0;
            db_is_cq <= 1'b0;
            db_value <= '0;
        end else begin
            db_valid <= wr_en && !drop;
            if (wr_en && !drop) begin
                db_qid   <= slot[QID_W-1:0];
                db_is_cq <= dw_idx[0];
                db_value <= wptr;
            end
        end
    end

    assert_event_source_R9: assert property (@(posedge clk) disable iff (rst)
        db_valid |-> $past(wr_en));

    assert_event_single_R9: assert property (@(posedge clk) disable iff (rst)
        db_valid |=> !db_valid || $past(wr_en));

    assert_drop_silent_R10: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && drop) |-> !db_valid);

endmodule

// File: rtl/sqc_rd_mux.sv
module sqc_rd_mux
    import sqc_pkg::*;
#(
    parameter int MQES    = 16,
    parameter int TIMEOUT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              full,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] stat_word,
    input  logic [DATA_W-1:0] aqa_word,
    input  logic [DATA_W-1:0] mask,
    input  logic [63:0]       asq,
    input  logic [63:0]       acq,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] CAP_LO = cap_low(MQES, TIMEOUT);

    logic [DATA_W-1:0] pick;

    always_comb begin
        case (sel)
            RS_CAP_LO:        pick = CAP_LO;
            RS_VER:           pick = VER_WORD;
            RS_MSET, RS_MCLR: pick = mask;
            RS_CFG:           pick = cfg_word;
            RS_STAT:          pick = stat_word;
            RS_AQA:           pick = aqa_word;
            RS_ASQ_LO:        pick = asq[31:0];
            RS_ASQ_HI:        pick = asq[63:32];
            RS_ACQ_LO:        pick = acq[31:0];
            RS_ACQ_HI:        pick = acq[63:32];
            default:          pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= full ? pick : '0;
    end

    assert_bad_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && (!full || sel == RS_NONE)) |-> rdata == '0);

endmodule

// File: rtl/sqc_regblk.sv
module sqc_regblk
    import sqc_pkg::*;
#(
    parameter int MQES    = 16,
    parameter int TIMEOUT = 10,
    parameter int MAX_QID = 1,
    localparam int QID_W  = (MAX_QID < 2) ? 1 : $clog2(MAX_QID + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [OFF_W-1:0]  bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              ctrl_ready,
    output logic [DATA_W-1:0] int_mask,
    output logic [63:0]       asq_base,
    output logic [63:0]       acq_base,
    output logic [QSZ_W-1:0]  asq_entries,
    output logic [QSZ_W-1:0]  acq_entries,
    output logic              db_valid,
    output logic [QID_W-1:0]  db_qid,
    output logic              db_is_cq,
    output logic [PTR_W-1:0]  db_value
);

    reg_sel_e          sel;
    logic              full, cfg_wr, db_wr, db_drop, bad;
    logic [DATA_W-1:0] cfg_word, stat_word, aqa_word;

    assign sel    = decode_offset(bus_addr);
    assign full   = (bus_be == 4'hF);
    assign cfg_wr = bus_wr && full && (sel != RS_NONE) && (sel != RS_DBELL);
    assign db_wr  = bus_wr && full && (sel == RS_DBELL);
    assign bad    = ((bus_wr || bus_rd) && (!full || sel == RS_NONE)) || (db_wr && db_drop);

    assign asq_entries = aqa_word[QSZ_W-1:0];
    assign acq_entries = aqa_word[16 +: QSZ_W];

    always_ff @(posedge clk) begin
        if (rst) bus_err <= 1'b0;
        else     bus_err <= bad;
    end

    sqc_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .cfg_word  (cfg_word),
        .stat_word (stat_word),
        .aqa_word  (aqa_word),
        .mask      (int_mask),
        .asq       (asq_base),
        .acq       (acq_base),
        .rdy       (ctrl_ready)
    );

    sqc_doorbell #(.MAX_QID(MAX_QID), .QID_W(QID_W)) u_db (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (db_wr),
        .dw_idx   (bus_addr[11:2]),
        .wptr     (bus_wdata[PTR_W-1:0]),
        .drop     (db_drop),
        .db_valid (db_valid),
        .db_qid   (db_qid),
        .db_is_cq (db_is_cq),
        .db_value (db_value)
    );

    sqc_rd_mux #(.MQES(MQES), .TIMEOUT(TIMEOUT)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (bus_rd),
        .full      (full),
        .sel       (sel),
        .cfg_word  (cfg_word),
        .stat_word (stat_word),
        .aqa_word  (aqa_word),
        .mask      (int_mask),
        .asq       (asq_base),
        .acq       (acq_base),
        .rdata     (bus_rdata)
    );

    assert_err_excl_event_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_err && db_valid));

    assert_bad_be_no_event_R11: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && !full) |-> !db_valid);

endmodule

// File: tb/sqc_regblk_tb_top.sv
module sqc_regblk_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, ctrl_ready, db_valid, db_is_cq;
    logic [31:0] int_mask;
    logic [63:0] asq_base, acq_base;
    logic [11:0] asq_entries, acq_entries;
    logic [0:0]  db_qid;
    logic [15:0] db_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sqc_regblk dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .ctrl_ready(ctrl_ready), .int_mask(int_mask), .asq_base(asq_base), .acq_base(acq_base),
        .asq_entries(asq_entries), .acq_entries(acq_entries), .db_valid(db_valid),
        .db_qid(db_qid), .db_is_cq(db_is_cq), .db_value(db_value)
    );

    // {write, offset, data, expected read}
    localparam logic [77:0] VEC [NVEC] = '{
        {1'b0, 13'h000, 32'h0, 32'h0A01_0010},
        {1'b0, 13'h004, 32'h0, 32'h0000_0000},
        {1'b0, 13'h008, 32'h0, 32'h0001_0000},
        {1'b1, 13'h024, 32'hF07F_F01F, 32'h0},
        {1'b0, 13'h024, 32'h0, 32'h007F_001F},
        {1'b1, 13'h028, 32'h1234_5ABC, 32'h0},
        {1'b0, 13'h028, 32'h0, 32'h1234_5000},
        {1'b1, 13'h02C, 32'h0000_00AB, 32'h0},
        {1'b0, 13'h02C, 32'h0, 32'h0000_00AB},
        {1'b1, 13'h030, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 13'h030, 32'h0, 32'hFFFF_F000},
        {1'b1, 13'h00C, 32'h0000_00F0, 32'h0},
        {1'b0, 13'h010, 32'h0, 32'h0000_00F0},
        {1'b1, 13'h010, 32'h0000_0030, 32'h0},
        {1'b0, 13'h00C, 32'h0, 32'h0000_00C0},
        {1'b1, 13'h000, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 13'h000, 32'h0, 32'h0A01_0010}
    };

    function automatic string vtag(input int i);
        if (i < 3)   return "R2";
        if (i < 5)   return "R7";
        if (i < 11)  return "R6";
        if (i < 15)  return "R8";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_be = 4'hF;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", ctrl_ready, 0);
        chk("R1 mask", int_mask, 0);
        chk("R1 asq", asq_base, 0);
        chk("R1 db_valid", db_valid, 0);
        chk("R1 err", bus_err, 0);
        rd(13'h01C, r); chk("R1 status", r, 0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][77]) wr(VEC[i][76:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][76:64], r);
                chk($sformatf("%s vec%0d", vtag(i), i), r, VEC[i][31:0]);
            end
        end
        chk("R2 ro write no err", bus_err, 0);

        chk("R6 asq out", asq_base, 64'h0000_00AB_1234_5000);
        chk("R6 acq out", acq_base, 64'h0000_0000_FFFF_F000);
        chk("R7 sq size", asq_entries, 12'h01F);
        chk("R7 cq size", acq_entries, 12'h07F);

        // R3 enable
        wr(13'h014, 32'h0046_0001);
        chk("R3 ready", ctrl_ready, 1);
        chk("R3 mask cleared", int_mask, 0);
        chk("R3 asq kept", asq_base, 64'h0000_00AB_1234_5000);
        chk("R3 size kept", asq_entries, 12'h01F);
        rd(13'h01C, r); chk("R3 status", r, 32'h1);
        rd(13'h014, r); chk("R5 cfg readback", r, 32'h0046_0001);
        wr(13'h014, 32'hFF00_000F);
        rd(13'h014, r); chk("R5 cfg mask", r, 32'h0000_0001);

        // R9 doorbells
        wr(13'h1000, 32'hABCD_0005);
        chk("R9 sq valid", db_valid, 1);
        chk("R9 sq qid", db_qid, 0);
        chk("R9 sq type", db_is_cq, 0);
        chk("R9 sq value", db_value, 16'h0005);
        chk("R9 sq no err", bus_err, 0);
        @(negedge clk);
        chk("R9 one cycle", db_valid, 0);
        wr(13'h100C, 32'h0001_0007);
        chk("R9 cq valid", db_valid, 1);
        chk("R9 cq qid", db_qid, 1);
        chk("R9 cq type", db_is_cq, 1);
        chk("R9 cq value", db_value, 16'h0007);

        // R10 out of range queue
        wr(13'h1010, 32'h0000_0003);
        chk("R10 no event", db_valid, 0);
        chk("R10 err", bus_err, 1);
        @(negedge clk);
        chk("R10 err one cycle", bus_err, 0);

        // R11 bad accesses
        wr(13'h00C, 32'h0000_00FF, 4'h3);
        chk("R11 partial err", bus_err, 1);
        chk("R11 partial no effect", int_mask, 0);
        wr(13'h1000, 32'h0000_0009, 4'h1);
        chk("R11 partial db no event", db_valid, 0);
        rd(13'h018, r);
        chk("R11 unmapped err", bus_err, 1);
        chk("R11 unmapped data", r, 0);
        rd(13'h016, r);
        chk("R11 unaligned err", bus_err, 1);

        // R5 shutdown codes
        wr(13'h014, 32'h0000_C001);
        rd(13'h01C, r); chk("R5 code3 no change", r, 32'h1);
        wr(13'h014, 32'h0000_4001);
        rd(13'h01C, r); chk("R5 normal done", r, 32'h9);

        // R4 disable
        wr(13'h014, 32'h0000_0000);
        chk("R4 ready low", ctrl_ready, 0);
        rd(13'h01C, r); chk("R4 shst kept", r, 32'h8);

        // R3 enable clears shutdown state
        wr(13'h014, 32'h0000_0001);
        rd(13'h01C, r); chk("R3 shst cleared", r, 32'h1);
        wr(13'h014, 32'h0000_0000);
        // R3 + R5 same write
        wr(13'h014, 32'h0000_8001);
        rd(13'h01C, r); chk("R5 enable with abrupt", r, 32'h9);
        chk("R3 ready with shutdown", ctrl_ready, 1);

        done = 1;
        finish_run();
    end

endmodule